// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block decides when a backup battery is tested and keeps the result of the last test. A digital comparator outside the block reports whether the battery is below its threshold. The block samples that comparator at a few moments only. The first moment is a short settling time after main power becomes valid. After that, the comparator is sampled again each time a long, fixed interval of clock cycles has passed, for as long as main power stays valid. Between these moments the comparator is ignored.

The result of a test is held as a sticky flag and driven out on an active-low indicator. A low-battery result stays visible until a later test finds the battery good, even if the comparator clears earlier. While main power is absent (battery backup), no test runs and the flag keeps its value. At the next power-up the flag is tested again. A one-cycle strobe marks the cycle in which a new result appears. The settling delay and the interval are parameters in clock cycles.

Top module: `battmon_top`

## Requirements
- R1: With `SETTLE_CYCLES` = S, the comparator is sampled on the (S+1)-th rising clock edge at which `supplyOk` is high after it rose. The new result is visible on `battLowN` right after that edge.
- R2: While `supplyOk` stays high, a further sample is taken every `INTERVAL_CYCLES` rising edges after the previous one.
- R3: `battLowN` is active low. It is 0 when the last sample saw `battBelow` = 1, and 1 when the last sample saw `battBelow` = 0.
- R4: Between samples, `battLowN` holds its value whatever `battBelow` does.
- R5: No sample is taken while `supplyOk` is low, including on a cycle where an interval sample would otherwise fall. The held value survives the loss of supply.
- R6: A drop of `supplyOk` cancels any settling or interval count in progress. The next rise starts the full power-up sequence of R1 again.
- R7: `checkStrobe` is 1 for exactly the one cycle in which a new sample result first appears on `battLowN`, and 0 otherwise.
- R8: While `rstN` is low, `battLowN` is 1, `checkStrobe` is 0 and no count is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | High while main power is valid |
| battBelow | input | 1 | Comparator result, high when the battery is below threshold |
| battLowN | output | 1 | Battery-low indicator, active low |
| checkStrobe | output | 1 | One-cycle pulse when a new test result appears |

## Verification
Two events can fall in the same cycle: the loss of main power and a due interval sample. The bench lets the interval count reach its last cycle and lowers `supplyOk` in exactly that cycle. At the same time it flips the comparator, so a sample taken in error would change the indicator. The check passes only if `battLowN` keeps its old value and `checkStrobe` stays 0. A second case drops power in the middle of the settling delay and then checks that the next power-up test comes a full settling time after the new rise.

// File: rtl/battmon_pkg.sv
package battmon_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } monState_t;

  // Strobes from control to the flag datapath
  typedef struct packed {
    logic sampleNow;  // take the comparator value this cycle
    logic backup;     // main supply absent
  } chkStrobe_t;

endpackage

// File: rtl/battmon_ctrl.sv
module battmon_ctrl
  import battmon_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES   = 4,
  parameter int unsigned INTERVAL_CYCLES = 16777216
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  output chkStrobe_t strobes
);

  localparam int unsigned SW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam int unsigned IW = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);
  localparam logic [IW-1:0] INTERVAL_LAST = IW'(INTERVAL_CYCLES - 1);

  monState_t     state;
  logic [SW-1:0] settleCnt;
  logic [IW-1:0] intCnt;
  logic          settleDone;
  logic          intDone;

  always_comb begin
    settleDone        = (state == ST_SETTLE) && (settleCnt == SETTLE_LAST);
    intDone           = (state == ST_RUN) && (intCnt == INTERVAL_LAST);
    strobes.sampleNow = supplyOk && (settleDone || intDone);
    strobes.backup    = !supplyOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      settleCnt <= '0;
      intCnt    <= '0;
    end else if (!supplyOk) begin
      state     <= ST_OFF;
      settleCnt <= '0;
      intCnt    <= '0;
    end else begin
      unique case (state)
        ST_OFF: begin
          state     <= ST_SETTLE;
          settleCnt <= '0;
        end
        ST_SETTLE: begin
          if (settleDone) begin
            state  <= ST_RUN;
            intCnt <= '0;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        ST_RUN: begin
          intCnt <= intDone ? '0 : intCnt + 1'b1;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  // R6
  offsupply_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (state == ST_OFF));

  // R1
  settle_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && settleDone) |=> (state == ST_RUN && intCnt == '0));

  // R2
  interval_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && state == ST_RUN && !intDone) |=> (intCnt == $past(intCnt) + 1'b1));

endmodule

// File: rtl/battmon_flag.sv
module battmon_flag
  import battmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  chkStrobe_t strobes,
  input  logic       battBelow,
  output logic       lowFlag,
  output logic       checkStrobe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowFlag     <= 1'b0;
      checkStrobe <= 1'b0;
    end else begin
      checkStrobe <= strobes.sampleNow;
      if (strobes.sampleNow) begin
        lowFlag <= battBelow;
      end
    end
  end

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sampleNow |=> $stable(lowFlag));

  // R5
  backup_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.backup |=> !checkStrobe);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    checkStrobe |=> !checkStrobe);

endmodule

// File: rtl/battmon_top.sv
module battmon_top
  import battmon_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES   = 4,
  parameter int unsigned INTERVAL_CYCLES = 16777216
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic battBelow,
  output logic battLowN,
  output logic checkStrobe
);

  chkStrobe_t strobes;
  logic       lowFlag;

  battmon_ctrl #(
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .INTERVAL_CYCLES(INTERVAL_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .supplyOk(supplyOk),
    .strobes (strobes)
  );

  battmon_flag u_flag (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .battBelow  (battBelow),
    .lowFlag    (lowFlag),
    .checkStrobe(checkStrobe)
  );

  assign battLowN = !lowFlag;

  // R8
  reset_state_chk: assert property (@(posedge clk) !rstN |-> (battLowN && !checkStrobe));

endmodule

// File: tb/battmon_top_tb.sv
module battmon_top_tb;

  localparam int unsigned SETTLE   = 4;
  localparam int unsigned INTERVAL = 20;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic battBelow = 1'b0;
  logic battLowN;
  logic checkStrobe;
  int   checkCnt = 0;
  int   failCnt = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  battmon_top #(
    .SETTLE_CYCLES  (SETTLE),
    .INTERVAL_CYCLES(INTERVAL)
  ) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .battBelow  (battBelow),
    .battLowN   (battLowN),
    .checkStrobe(checkStrobe)
  );

  // {supplyOk, battBelow, cycles[7:0], expLowN, expStrobe, reqId[3:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'd4,  1'b1, 1'b0, 4'd1}, // R1 not yet sampled
    {1'b1, 1'b1, 8'd1,  1'b0, 1'b1, 4'd1}, // R1 power-up sample, R3 low
    {1'b1, 1'b0, 8'd1,  1'b0, 1'b0, 4'd4}, // R4 comparator clears, held
    {1'b1, 1'b0, 8'd18, 1'b0, 1'b0, 4'd4}, // R4 held to interval end
    {1'b1, 1'b0, 8'd1,  1'b1, 1'b1, 4'd2}, // R2 interval sample clears
    {1'b1, 1'b1, 8'd19, 1'b1, 1'b0, 4'd4}, // R4 goes low but ignored
    {1'b1, 1'b1, 8'd1,  1'b0, 1'b1, 4'd2}, // R2 next interval sample
    {1'b0, 1'b0, 8'd30, 1'b0, 1'b0, 4'd5}, // R5 backup, value retained
    {1'b1, 1'b0, 8'd4,  1'b0, 1'b0, 4'd1}, // R1 settling
    {1'b1, 1'b0, 8'd1,  1'b1, 1'b1, 4'd3}, // R3 good battery reads 1
    {1'b1, 1'b1, 8'd19, 1'b1, 1'b0, 4'd4}, // R4 up to due cycle
    {1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 4'd5}, // R5 supply lost on due cycle
    {1'b0, 1'b1, 8'd5,  1'b1, 1'b0, 4'd5}, // R5 still no sample
    {1'b1, 1'b1, 8'd3,  1'b1, 1'b0, 4'd6}, // R6 partial settle
    {1'b0, 1'b1, 8'd2,  1'b1, 1'b0, 4'd6}, // R6 glitch cancels
    {1'b1, 1'b1, 8'd4,  1'b1, 1'b0, 4'd6}, // R6 full settle again
    {1'b1, 1'b1, 8'd1,  1'b0, 1'b1, 4'd6}, // R6 sample after new rise
    {1'b1, 1'b0, 8'd19, 1'b0, 1'b0, 4'd4}, // R4 held while comparator good
    {1'b1, 1'b0, 8'd1,  1'b1, 1'b1, 4'd7}  // R7 strobe with new result
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    runCycles(3);
    check("R8", battLowN, 1'b1, "battLowN in reset");
    check("R8", checkStrobe, 1'b0, "checkStrobe in reset");
    rstN = 1'b1;
    runCycles(2);
    check("R8", battLowN, 1'b1, "battLowN idle after reset");

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      supplyOk  = VEC[v][15];
      battBelow = VEC[v][14];
      runCycles(int'(VEC[v][13:6]));
      tag = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
      check(tag, battLowN, VEC[v][5], "battLowN");
      check(tag, checkStrobe, VEC[v][4], "checkStrobe");
    end

    // R7: strobe lasts a single cycle
    runCycles(1);
    check("R7", checkStrobe, 1'b0, "strobe after one cycle");

    // R3 and R8: get a low result, then reset mid-run
    battBelow = 1'b1;
    runCycles(18);
    check("R4", battLowN, 1'b1, "held before due sample");
    runCycles(1);
    check("R3", battLowN, 1'b0, "low after interval sample");
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R8", battLowN, 1'b1, "async reset clears indicator");
    check("R8", checkStrobe, 1'b0, "async reset clears strobe");
    runCycles(2);
    rstN = 1'b1;
    runCycles(SETTLE);
    check("R8", battLowN, 1'b1, "no sample before settle after reset");
    runCycles(1);
    check("R1", battLowN, 1'b0, "power-up sample after reset");
    check("R7", checkStrobe, 1'b1, "strobe after reset sample");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule